// File: doc/BRIEF.md
# Standby Power Sequencer

This block moves a system between a run state on its fast clock and a standby state on a slow always-on clock. It runs entirely on the slow clock. Software issues a one-cycle sleep command. The block then takes the fast domain down step by step: it stops the system timer, gates the fast-clock peripherals, and steers the system clock multiplexer to the slow source. After the multiplexer acknowledges, it turns the fast oscillator off. Only when all of that is done does it ask the regulators or the external supply to power down.

Enabled external interrupts bring the system back up. Each interrupt line is synchronised to the slow clock and has its own enable bit. Wake-up retraces the same steps backwards. A wake that arrives part-way through the shutdown lets the current step finish and then turns back at that point, without ever reaching standby. The clock multiplexer and the oscillator are outside the block. Each is seen only through a single acknowledge or ready signal.

Top module: `standby_sequencer`

## Requirements
- R1: While `rst` is high and after it falls, outputs show the run setting: `tmr_en`=1, `periph_en`=1, `clk_sel_slow`=0, `osc_en`=1, `reg_pdn`=0, `state_o`=0, `wake_done`=0.
- R2: When `sleep_req` is sampled high in run, `tmr_en` drops at that edge. `periph_en` drops at the next edge, and `clk_sel_slow` rises at the edge after that. Each step takes one slow-clock cycle.
- R3: `osc_en` falls at the edge after `clksel_ack` is first sampled high. Until then `osc_en` stays 1 and `state_o` stays 1.
- R4: One edge after `osc_en` falls, the block enters standby: `reg_pdn`=1 and `state_o`=2. `reg_pdn` is never 1 unless `osc_en`=0 and `clk_sel_slow`=1.
- R5: Wake line i counts only while `wake_en[i]`=1. A line with its enable at 0 leaves standby unchanged. A line passes through `SYNC_STAGES` flops and is then latched, so a one-cycle pulse is enough. With the default of two stages, a pulse driven before edge e releases `reg_pdn` at edge e+2.
- R6: The wake order is as follows:
  - `reg_pdn` falls.
  - At the next edge `osc_en` rises.
  - `clk_sel_slow` falls at the edge after `osc_ready` is sampled high.
  - `periph_en` rises at the edge after `clksel_ack` is sampled low.
  - At the next edge `tmr_en` rises and the block is back in run.
- R7: A wake seen during shutdown completes the step in progress, then undoes the completed steps in reverse order without entering standby:
  - From the timer step it goes straight back to run.
  - From the peripheral step it turns the peripherals back on.
  - From the clock-switch step it waits for the acknowledge and then switches back.
  - From the oscillator-off step it re-enables the oscillator.
- R8: `state_o` encodes the phase: 0 run, 1 shutting down, 2 standby, 3 waking. `wake_done` is high for exactly the first cycle of run after any wake or reversal.
- R9: `sleep_req` has no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Always-on slow clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Software sleep command, sampled only in run |
| wake_irq | input | N_WAKE | External interrupt lines, asynchronous |
| wake_en | input | N_WAKE | Per-line wake enable |
| clksel_ack | input | 1 | Clock multiplexer reports slow source selected (1) or fast (0) |
| osc_ready | input | 1 | Fast oscillator stable |
| tmr_en | output | 1 | System timer enable |
| periph_en | output | 1 | Fast-clock peripheral enable |
| clk_sel_slow | output | 1 | Clock multiplexer request: 1 selects slow source |
| osc_en | output | 1 | Fast oscillator enable |
| reg_pdn | output | 1 | Regulator / supply power-down request |
| state_o | output | 2 | Phase code (R8) |
| wake_done | output | 1 | One-cycle pulse on return to run |

## Verification
All outputs are registered from the next state, so each one moves at the same edge as the step that owns it. A step that needs no handshake therefore shows its effect one slow-clock cycle after the step before it. The shutdown starts one edge after `sleep_req`. A wake pulse shows at the third edge after it is driven: two synchroniser flops, then the sequencer. Handshake steps take one edge after the acknowledge is sampled.

A scoreboard compares every change of the combined output vector against a queue filled before each stimulus. This covers the order and the exact route of every reversal. Direct checks taken at the falling edge pin down the first-step latency, the wake latency, and the holds while an acknowledge is still outstanding. The bench models the multiplexer and the oscillator with delays that can be set per test.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    EN_TMR,
    EN_PER,
    EN_SEL,
    EN_OSC,
    ST_STBY,
    EX_PWR,
    EX_OSC,
    EX_SEL,
    EX_PER
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_ENTER = 2'd1,
    PH_STBY  = 2'd2,
    PH_EXIT  = 2'd3
  } phase_e;

  typedef struct packed {
    logic tmr_en;
    logic periph_en;
    logic sel_slow;
    logic osc_en;
    logic reg_pdn;
  } ctrl_t;

  localparam ctrl_t CTRL_RUN = '{tmr_en: 1'b1, periph_en: 1'b1, sel_slow: 1'b0,
                                 osc_en: 1'b1, reg_pdn: 1'b0};

  function automatic ctrl_t ctrl_of(seq_state_e s);
    ctrl_t c;
    case (s)
      ST_RUN:  c = CTRL_RUN;
      EN_TMR:  c = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      EN_PER:  c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      EN_SEL:  c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
      EN_OSC:  c = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      ST_STBY: c = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
      EX_PWR:  c = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      EX_OSC:  c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
      EX_SEL:  c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      EX_PER:  c = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      default: c = CTRL_RUN;
    endcase
    return c;
  endfunction

  function automatic phase_e phase_of(seq_state_e s);
    phase_e p;
    case (s)
      ST_RUN:                         p = PH_RUN;
      EN_TMR, EN_PER, EN_SEL, EN_OSC: p = PH_ENTER;
      ST_STBY:                        p = PH_STBY;
      default:                        p = PH_EXIT;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/stby_wake_sync.sv
module stby_wake_sync #(
  parameter int N_WAKE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_WAKE-1:0] irq,
  input  logic [N_WAKE-1:0] en,
  input  logic              clr,
  output logic              wake
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [N_WAKE-1:0][SYNC_STAGES-1:0] chain_q;
  logic [N_WAKE-1:0]                  synced;
  logic                               hit;
  logic                               pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      for (int i = 0; i < N_WAKE; i++) begin
        chain_q[i] <= SYNC_STAGES'({chain_q[i], irq[i]});
      end
    end
  end

  for (genvar g = 0; g < N_WAKE; g++) begin : g_tap
    assign synced[g] = chain_q[g][LAST];
  end

  assign hit = |(synced & en);

  // latch so a short pulse survives until the sequencer can act on it
  always_ff @(posedge clk) begin
    if (rst || clr) pend_q <= 1'b0;
    else if (hit)   pend_q <= 1'b1;
  end

  assign wake = hit | pend_q;

endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       wake,
  input  logic       clksel_ack,
  input  logic       osc_ready,
  output seq_state_e state_q,
  output seq_state_e state_d
);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (sleep_req) state_d = EN_TMR;
      EN_TMR:  state_d = wake ? ST_RUN : EN_PER;
      EN_PER:  state_d = wake ? EX_PER : EN_SEL;
      EN_SEL:  if (clksel_ack) state_d = wake ? EX_SEL : EN_OSC;
      EN_OSC:  state_d = wake ? EX_OSC : ST_STBY;
      ST_STBY: if (wake) state_d = EX_PWR;
      EX_PWR:  state_d = EX_OSC;
      EX_OSC:  if (osc_ready) state_d = EX_SEL;
      EX_SEL:  if (!clksel_ack) state_d = EX_PER;
      EX_PER:  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/stby_out_regs.sv
module stby_out_regs
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_q,
  input  seq_state_e state_d,
  output ctrl_t      ctrl_q,
  output phase_e     phase_q,
  output logic       done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RUN;
      phase_q <= PH_RUN;
      done_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_of(state_d);
      phase_q <= phase_of(state_d);
      done_q  <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

endmodule

// File: rtl/standby_sequencer.sv
module standby_sequencer
  import stby_pkg::*;
#(
  parameter int N_WAKE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_slow,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic [N_WAKE-1:0] wake_irq,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic              clksel_ack,
  input  logic              osc_ready,
  output logic              tmr_en,
  output logic              periph_en,
  output logic              clk_sel_slow,
  output logic              osc_en,
  output logic              reg_pdn,
  output logic [1:0]        state_o,
  output logic              wake_done
);

  seq_state_e state_q;
  seq_state_e state_d;
  ctrl_t      ctrl_q;
  phase_e     phase_q;
  logic       wake;

  stby_wake_sync #(
    .N_WAKE     (N_WAKE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_wake (
    .clk (clk_slow),
    .rst (rst),
    .irq (wake_irq),
    .en  (wake_en),
    .clr (state_q == ST_RUN),
    .wake(wake)
  );

  stby_seq_fsm u_fsm (
    .clk       (clk_slow),
    .rst       (rst),
    .sleep_req (sleep_req),
    .wake      (wake),
    .clksel_ack(clksel_ack),
    .osc_ready (osc_ready),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  stby_out_regs u_out (
    .clk    (clk_slow),
    .rst    (rst),
    .state_q(state_q),
    .state_d(state_d),
    .ctrl_q (ctrl_q),
    .phase_q(phase_q),
    .done_q (wake_done)
  );

  assign tmr_en       = ctrl_q.tmr_en;
  assign periph_en    = ctrl_q.periph_en;
  assign clk_sel_slow = ctrl_q.sel_slow;
  assign osc_en       = ctrl_q.osc_en;
  assign reg_pdn      = ctrl_q.reg_pdn;
  assign state_o      = phase_q;

endmodule

// File: rtl/stby_sequencer_chk.sv
module stby_sequencer_chk (
  input logic       clk_slow,
  input logic       rst,
  input logic       clksel_ack,
  input logic       osc_ready,
  input logic       tmr_en,
  input logic       periph_en,
  input logic       clk_sel_slow,
  input logic       osc_en,
  input logic       reg_pdn,
  input logic [1:0] state_o,
  input logic       wake_done
);

  p_per_off_after_tmr_r2: assert property (@(posedge clk_slow) disable iff (rst)
    $fell(periph_en) |-> !tmr_en);

  p_sel_after_per_r2: assert property (@(posedge clk_slow) disable iff (rst)
    $rose(clk_sel_slow) |-> (!periph_en && !tmr_en));

  p_osc_off_after_ack_r3: assert property (@(posedge clk_slow) disable iff (rst)
    $fell(osc_en) |-> (clk_sel_slow && $past(clksel_ack)));

  p_pdn_safe_r4: assert property (@(posedge clk_slow) disable iff (rst)
    reg_pdn |-> (!osc_en && clk_sel_slow && state_o == 2'd2));

  p_osc_on_after_release_r6: assert property (@(posedge clk_slow) disable iff (rst)
    $rose(osc_en) |-> !reg_pdn);

  p_fast_sel_needs_ready_r6: assert property (@(posedge clk_slow) disable iff (rst)
    $fell(clk_sel_slow) |-> (osc_en && $past(osc_ready)));

  p_per_on_after_fast_r6: assert property (@(posedge clk_slow) disable iff (rst)
    $rose(periph_en) |-> (!clk_sel_slow && !$past(clksel_ack)));

  p_done_single_r8: assert property (@(posedge clk_slow) disable iff (rst)
    wake_done |=> !wake_done);

  p_done_in_run_r8: assert property (@(posedge clk_slow) disable iff (rst)
    wake_done |-> (state_o == 2'd0 && tmr_en));

endmodule

bind standby_sequencer stby_sequencer_chk u_chk (
  .clk_slow    (clk_slow),
  .rst         (rst),
  .clksel_ack  (clksel_ack),
  .osc_ready   (osc_ready),
  .tmr_en      (tmr_en),
  .periph_en   (periph_en),
  .clk_sel_slow(clk_sel_slow),
  .osc_en      (osc_en),
  .reg_pdn     (reg_pdn),
  .state_o     (state_o),
  .wake_done   (wake_done)
);

// File: tb/standby_sequencer_tb_top.sv
module standby_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW         = 4;
  localparam int WD_LIMIT   = 100000;

  // vector layout: {phase[1:0], tmr, per, sel, osc, pdn, done}
  localparam logic [7:0] V_RUN_DONE = 8'b00_11010_1;
  localparam logic [7:0] V_RUN      = 8'b00_11010_0;
  localparam logic [7:0] V_E_TMR    = 8'b01_01010_0;
  localparam logic [7:0] V_E_PER    = 8'b01_00010_0;
  localparam logic [7:0] V_E_SEL    = 8'b01_00110_0;
  localparam logic [7:0] V_E_OSC    = 8'b01_00100_0;
  localparam logic [7:0] V_STBY     = 8'b10_00101_0;
  localparam logic [7:0] V_X_PWR    = 8'b11_00100_0;
  localparam logic [7:0] V_X_OSC    = 8'b11_00110_0;
  localparam logic [7:0] V_X_SEL    = 8'b11_00010_0;
  localparam logic [7:0] V_X_PER    = 8'b11_01010_0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_req = 1'b0;
  logic [NW-1:0] wake_irq = '0;
  logic [NW-1:0] wake_en = '0;
  logic          clksel_ack;
  logic          osc_ready;
  logic          tmr_en, periph_en, clk_sel_slow, osc_en, reg_pdn, wake_done;
  logic [1:0]    state_o;

  int n_checks = 0;
  int n_errors = 0;
  int ack_delay = 4;
  int osc_delay = 3;
  int acnt, ocnt;
  int cyc = 0;
  bit mon_on = 1'b0;
  logic [7:0] prev_v;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_sequencer #(.N_WAKE(NW), .SYNC_STAGES(2)) dut_i (
    .clk_slow(clk), .rst(rst), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .wake_en(wake_en), .clksel_ack(clksel_ack), .osc_ready(osc_ready),
    .tmr_en(tmr_en), .periph_en(periph_en), .clk_sel_slow(clk_sel_slow),
    .osc_en(osc_en), .reg_pdn(reg_pdn), .state_o(state_o), .wake_done(wake_done)
  );

  wire [7:0] obs = {state_o, tmr_en, periph_en, clk_sel_slow, osc_en, reg_pdn, wake_done};

  // clock multiplexer model: acknowledge follows the request after ack_delay edges
  always @(posedge clk) begin
    if (rst) begin
      clksel_ack <= 1'b0; acnt <= 0;
    end else if (clksel_ack != clk_sel_slow) begin
      if (acnt + 1 >= ack_delay) begin clksel_ack <= clk_sel_slow; acnt <= 0; end
      else acnt <= acnt + 1;
    end else acnt <= 0;
  end

  // oscillator model: ready osc_delay edges after enable, drops at once when disabled
  always @(posedge clk) begin
    if (rst) begin
      osc_ready <= 1'b1; ocnt <= 0;
    end else if (!osc_en) begin
      osc_ready <= 1'b0; ocnt <= 0;
    end else if (!osc_ready) begin
      if (ocnt + 1 >= osc_delay) begin osc_ready <= 1'b1; ocnt <= 0; end
      else ocnt <= ocnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic wait_run();
    do @(negedge clk); while (!(state_o == 2'd0 && !wake_done));
  endtask

  // monitor: every change of the output vector is popped and compared
  always @(negedge clk) begin
    if (mon_on && obs !== prev_v) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard unexpected change", obs, prev_v);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, obs, e);
      end
      prev_v = obs;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 outputs during reset", obs, V_RUN);
    tick(3);
    rst = 1'b0;
    tick(2);
    chk("R1 after reset", obs, V_RUN);
    chk("R8 status after reset", {6'd0, state_o}, 8'd0);
    prev_v = obs;
    mon_on = 1'b1;

    // full shutdown
    wake_en = 4'b0001;
    push(V_E_TMR, "R2 timer off"); push(V_E_PER, "R2 peripherals off");
    push(V_E_SEL, "R2 select slow"); push(V_E_OSC, "R3 osc off after ack");
    push(V_STBY, "R4 standby");
    pulse_sleep();
    chk("R2 timer off one edge after request", {7'd0, tmr_en}, 8'd0);
    do @(negedge clk); while (!clk_sel_slow);
    tick(2);
    chk("R3 osc held while ack pending", {6'd0, osc_en, state_o == 2'd1}, 8'b11);
    do @(negedge clk); while (state_o != 2'd2);
    chk("R4 power-down in standby", {7'd0, reg_pdn}, 8'd1);

    // sleep request in standby ignored
    pulse_sleep();
    tick(5);
    chk("R9 sleep ignored in standby", obs, V_STBY);

    // disabled wake source ignored
    wake_irq[2] = 1'b1;
    tick(8);
    wake_irq[2] = 1'b0;
    tick(4);
    chk("R5 disabled source ignored", obs, V_STBY);

    // full wake from one-cycle pulse
    push(V_X_PWR, "R6 release power-down"); push(V_X_OSC, "R6 osc on");
    push(V_X_SEL, "R6 select fast"); push(V_X_PER, "R6 peripherals on");
    push(V_RUN_DONE, "R8 done on run entry"); push(V_RUN, "R8 done one cycle");
    wake_irq[0] = 1'b1;
    @(negedge clk);
    wake_irq[0] = 1'b0;
    @(negedge clk);
    chk("R5 power-down held during sync", {7'd0, reg_pdn}, 8'd1);
    @(negedge clk);
    chk("R5 power-down released at third edge", {7'd0, reg_pdn}, 8'd0);
    do @(negedge clk); while (!osc_en);
    @(negedge clk);
    chk("R6 slow select held until osc ready", {7'd0, clk_sel_slow}, 8'd1);
    wait_run();
    tick(4);

    // reversal from the timer step
    push(V_E_TMR, "R7 timer step"); push(V_RUN_DONE, "R7 back to run from timer step");
    push(V_RUN, "R8 done one cycle");
    wake_irq[0] = 1'b1;
    @(negedge clk);
    pulse_sleep();
    tick(6);
    wake_irq[0] = 1'b0;
    tick(6);

    // reversal from the peripheral step
    push(V_E_TMR, "R7 timer step"); push(V_E_PER, "R7 peripheral step");
    push(V_X_PER, "R7 peripherals back on"); push(V_RUN_DONE, "R7 back to run");
    push(V_RUN, "R8 done one cycle");
    wake_irq[0] = 1'b1;
    pulse_sleep();
    tick(6);
    wake_irq[0] = 1'b0;
    tick(6);

    // reversal from the clock-switch step
    ack_delay = 6;
    wake_en = 4'b0010;
    push(V_E_TMR, "R7 timer step"); push(V_E_PER, "R7 peripheral step");
    push(V_E_SEL, "R7 switch step"); push(V_X_SEL, "R7 switch back after ack");
    push(V_X_PER, "R7 peripherals back on"); push(V_RUN_DONE, "R7 back to run");
    push(V_RUN, "R8 done one cycle");
    pulse_sleep();
    do @(negedge clk); while (!clk_sel_slow);
    wake_irq[1] = 1'b1;
    @(negedge clk);
    wake_irq[1] = 1'b0;
    wait_run();
    chk("R7 no standby reached", {7'd0, reg_pdn}, 8'd0);
    tick(4);

    // second full cycle with short handshakes and another source
    ack_delay = 1;
    osc_delay = 1;
    wake_en = 4'b1000;
    push(V_E_TMR, "R2 timer off"); push(V_E_PER, "R2 peripherals off");
    push(V_E_SEL, "R2 select slow"); push(V_E_OSC, "R3 osc off");
    push(V_STBY, "R4 standby");
    push(V_X_PWR, "R6 release power-down"); push(V_X_OSC, "R6 osc on");
    push(V_X_SEL, "R6 select fast"); push(V_X_PER, "R6 peripherals on");
    push(V_RUN_DONE, "R8 done on run entry"); push(V_RUN, "R8 done one cycle");
    pulse_sleep();
    do @(negedge clk); while (state_o != 2'd2);
    tick(3);
    wake_irq[3] = 1'b1;
    tick(2);
    wake_irq[3] = 1'b0;
    wait_run();
    tick(4);

    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule